// File: doc/BRIEF.md
# Banked Scratchpad with Conflict Replay

This block is an on-chip scratchpad split into word-interleaved banks. It serves a whole group of lanes as one request. Each lane gives a word address and, for a store, a data word. A lane mask selects which lanes take part. The block works out which lanes can share a cycle. Lanes that land in different banks go together. Lanes that need the same bank word also go together, as a broadcast. Lanes that need different words of one bank are served in later cycles, one word per bank per cycle.

A mode input sets the bank width for each request. In narrow mode a bank holds one 32-bit word per row. In wide mode a bank holds two adjacent 32-bit words per row, so both halves of an aligned pair can be served in one cycle. Storage is addressed by word in both modes. Data written in one mode reads back the same in the other.

The unit takes one request whenever `ready` is high. It then holds `ready` low while it replays the request. When the last lanes have been served, `done` pulses for one cycle, the per-lane read results become valid on `rd_data`, and `ready` rises again.

Top module: `banked_scratchpad`

## Requirements
- R1: During reset and in the first cycle after it, `ready` is 1 and `done` is 0.
- R2: In narrow mode (`req_wide`=0) the bank of a lane is bits [4:0] of its word address. Lanes whose banks are all distinct are served in one cycle, so `done` rises on the first clock edge after the accept edge.
- R3: Define the number of service cycles S as the largest count, over all banks, of distinct bank words wanted by active lanes (at least 1). `done` is high exactly S clock edges after the accept edge, and not before.
- R4: Lanes that want the same word are served together by broadcast and add no cycle. Any number of such broadcast groups, each in its own bank, are all served in the same cycle.
- R5: In wide mode (`req_wide`=1) a bank word is the aligned word pair given by address bits [AW-1:1], and the bank is bits [5:1]. Both words of one pair count as a single bank word.
- R6: In narrow mode, 32 lanes reading word addresses 2*i take 2 service cycles. In wide mode the same pattern takes 1.
- R7: In narrow mode, 32 lanes reading word addresses 3*i take 1 service cycle.
- R8: A store request writes `req_wdata` of every active lane to its address. When several active lanes store to the same address, the value of the highest-numbered of those lanes remains.
- R9: When `done` is high, `rd_data` lane i holds the stored word at that lane's address if lane i was active in a load. It holds 0 for inactive lanes and for every lane of a store request. The value stays until the next accept.
- R10: `ready` is low from the accept edge until the cycle in which `done` is high, and `done` lasts one cycle. A request presented while `ready` is low is ignored and does not change storage.
- R11: A request with an all-zero mask takes 1 service cycle and changes no storage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present; taken on a clock edge where `ready` is 1 |
| req_write | input | 1 | 1 = store request, 0 = load request |
| req_wide | input | 1 | Bank width: 0 = 32-bit banks, 1 = 64-bit banks |
| req_mask | input | LANES | Lane i takes part when bit i is 1 |
| req_addr | input | LANES x AW | Word address of each lane |
| req_wdata | input | LANES x DW | Store data of each lane |
| ready | output | 1 | Unit idle and able to take a request |
| done | output | 1 | One-cycle pulse when the request is complete |
| rd_data | output | LANES x DW | Per-lane load results, valid while `done` is high and held after it |

## Verification
Two things can happen in the same service cycle: broadcast of one word to many lanes, and serialization of different words in the same bank. The bench sets up requests where both occur at once. In one, two broadcast groups share a bank and must take two cycles. In another, groups sit in separate banks and must take one. A third uses scattered addresses whose collisions mix shared words with bank conflicts. A behavioural model counts distinct bank words per bank with plain loops and compares `ready` and `done` on every clock. When `done` rises, it checks every lane's read data. This shows whether the block merges the broadcast lanes and still defers each conflicting word. Write-priority collisions and requests presented while busy are judged by reading the affected words back afterwards.

// File: rtl/sp_pkg.sv
// Package: shared types for the banked scratchpad.
// Holds the bank-width mode encoding used by the scheduler and the top level.
package sp_pkg;

    // Bank width selected per request: one word per bank row, or an aligned pair.
    typedef enum logic {
        BANK_NARROW = 1'b0,
        BANK_WIDE   = 1'b1
    } bank_mode_e;

endpackage

// File: rtl/sp_bank_sched.sv
// Module: sp_bank_sched
// Picks, for one service cycle, the lanes that can be served together.
// In each bank the lowest-numbered pending lane decides the bank word. Every
// pending lane that wants that same bank word (same word or, in wide mode, the
// same aligned pair) is served alongside it. All other lanes of that bank wait.
// Assumes: BANKS is a power of two and AW > log2(BANKS).
module sp_bank_sched #(
    parameter int LANES = 32,
    parameter int BANKS = 32,
    parameter int AW    = 11
) (
    input  logic [LANES-1:0]          pending,
    input  logic [LANES-1:0][AW-1:0]  lane_addr,
    input  sp_pkg::bank_mode_e        mode,
    output logic [LANES-1:0]          served
);
    localparam int BW = $clog2(BANKS);

    logic [LANES-1:0][BW-1:0] bank_idx;
    logic [LANES-1:0][AW-1:0] bank_word;
    logic [LANES-1:0]         leader;

    // Map every lane to its bank and to the bank word it needs.
    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            if (mode == sp_pkg::BANK_WIDE) begin
                bank_idx[i]  = lane_addr[i][BW:1];
                bank_word[i] = {1'b0, lane_addr[i][AW-1:1]};
            end else begin
                bank_idx[i]  = lane_addr[i][BW-1:0];
                bank_word[i] = lane_addr[i];
            end
        end
    end

    // A leader is the lowest pending lane in its bank.
    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            leader[i] = pending[i];
            for (int j = 0; j < i; j++) begin
                if (pending[j] && bank_idx[j] == bank_idx[i]) leader[i] = 1'b0;
            end
        end
    end

    // Serve each pending lane whose bank word matches its bank leader's word.
    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            served[i] = 1'b0;
            for (int j = 0; j < LANES; j++) begin
                if (pending[i] && leader[j] && bank_idx[j] == bank_idx[i]
                    && bank_word[j] == bank_word[i]) served[i] = 1'b1;
            end
        end
    end

    // Check that no bank is asked for two different words in one cycle, and that
    // pending work always moves forward.
    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            for (int j = 0; j < LANES; j++) begin
                AST_ONE_WORD_PER_BANK: assert (!(served[i] && served[j]
                    && bank_idx[i] == bank_idx[j] && bank_word[i] != bank_word[j]))
                    else $error("two bank words served in one bank"); // R3
            end
        end
        AST_PROGRESS: assert (pending == '0 || served != '0)
            else $error("pending lanes but none served"); // R3
    end

endmodule

// File: rtl/sp_storage.sv
// Module: sp_storage
// Word-addressed storage array. It writes the served lanes and reads for every
// lane without waiting.
// Bank interleaving is handled by the scheduler. The array is addressed by whole
// word, so data keeps its place whichever bank width is in use.
// Assumes: addresses are below WORDS. Writes go in ascending lane order, so the
// highest served lane wins an address collision. Contents are not reset.
module sp_storage #(
    parameter int LANES = 32,
    parameter int WORDS = 2048,
    parameter int DW    = 32,
    parameter int AW    = 11
) (
    input  logic                      clk,
    input  logic                      wr_en,
    input  logic [LANES-1:0]          lane_sel,
    input  logic [LANES-1:0][AW-1:0]  lane_addr,
    input  logic [LANES-1:0][DW-1:0]  lane_wdata,
    output logic [LANES-1:0][DW-1:0]  lane_rword
);
    logic [DW-1:0] mem [WORDS];

    // Apply the served stores. A later lane's assignment replaces an earlier one.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            for (int i = 0; i < LANES; i++) begin
                if (lane_sel[i]) mem[lane_addr[i]] <= lane_wdata[i];
            end
        end
    end

    // Read port for each lane.
    always_comb begin
        for (int i = 0; i < LANES; i++) lane_rword[i] = mem[lane_addr[i]];
    end

endmodule

// File: rtl/sp_ctrl.sv
// Module: sp_ctrl
// Request sequencer. It accepts a request while idle, keeps the set of lanes not
// yet served, clears the lanes served in each cycle, and pulses done once the
// set is empty.
// Assumes: the served vector is a subset of pending. An all-zero mask still
// takes one service cycle.
module sp_ctrl #(
    parameter int LANES = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [LANES-1:0] req_mask,
    input  logic [LANES-1:0] served,
    output logic             accept,
    output logic             busy,
    output logic             done,
    output logic [LANES-1:0] pending
);
    logic [LANES-1:0] left_after;

    assign accept     = !busy && req_valid;
    assign left_after = pending & ~served;

    // Track request progress: load on accept, shrink per service cycle, finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            done    <= 1'b0;
            pending <= '0;
        end else begin
            done <= 1'b0;
            if (accept) begin
                busy    <= 1'b1;
                pending <= req_mask;
            end else if (busy) begin
                pending <= left_after;
                if (left_after == '0) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done) else $error("done longer than one cycle"); // R10
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && pending == '0)) else $error("done while work left"); // R10
    AST_PENDING_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ((pending & ~$past(pending)) == '0)) else $error("pending grew"); // R3

endmodule

// File: rtl/banked_scratchpad.sv
// Module: banked_scratchpad (top)
// Multi-lane banked scratchpad. On accept it captures the request. Each cycle
// the scheduler picks the lanes free of bank conflicts. Stores are applied,
// loads are captured per lane, and the sequencer replays until every active
// lane has been served.
// Assumes: BANKS is a power of two, WORDS is a multiple of 2*BANKS, and the
// requester keeps each address below WORDS.
module banked_scratchpad #(
    parameter int LANES = 32,
    parameter int BANKS = 32,
    parameter int WORDS = 2048,
    parameter int DW    = 32,
    localparam int AW   = $clog2(WORDS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    input  logic                      req_write,
    input  logic                      req_wide,
    input  logic [LANES-1:0]          req_mask,
    input  logic [LANES-1:0][AW-1:0]  req_addr,
    input  logic [LANES-1:0][DW-1:0]  req_wdata,
    output logic                      ready,
    output logic                      done,
    output logic [LANES-1:0][DW-1:0]  rd_data
);
    logic                      accept;
    logic                      busy;
    logic [LANES-1:0]          pending;
    logic [LANES-1:0]          served;
    logic [LANES-1:0][AW-1:0]  addr_q;
    logic [LANES-1:0][DW-1:0]  wdata_q;
    logic [LANES-1:0][DW-1:0]  rword;
    logic                      write_q;
    sp_pkg::bank_mode_e        mode_q;

    // Capture the request fields on accept and hold them through replay.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            write_q <= 1'b0;
            mode_q  <= sp_pkg::BANK_NARROW;
        end else if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            write_q <= req_write;
            mode_q  <= sp_pkg::bank_mode_e'(req_wide);
        end
    end

    sp_ctrl #(.LANES(LANES)) ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_mask  (req_mask),
        .served    (served),
        .accept    (accept),
        .busy      (busy),
        .done      (done),
        .pending   (pending)
    );

    sp_bank_sched #(.LANES(LANES), .BANKS(BANKS), .AW(AW)) sched_i (
        .pending   (pending),
        .lane_addr (addr_q),
        .mode      (mode_q),
        .served    (served)
    );

    sp_storage #(.LANES(LANES), .WORDS(WORDS), .DW(DW), .AW(AW)) store_i (
        .clk        (clk),
        .wr_en      (busy && write_q),
        .lane_sel   (served),
        .lane_addr  (addr_q),
        .lane_wdata (wdata_q),
        .lane_rword (rword)
    );

    // Per-lane load results: cleared on accept, filled as lanes are served.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (accept) begin
            rd_data <= '0;
        end else if (busy && !write_q) begin
            for (int i = 0; i < LANES; i++) begin
                if (served[i]) rd_data[i] <= rword[i];
            end
        end
    end

    assign ready = !busy;

    AST_HOLD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |=> ($stable(addr_q) && $stable(write_q))) else $error("request changed mid-replay"); // R10
    AST_IDLE_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (served == '0)) else $error("lanes served while idle"); // R10
    AST_STORE_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && write_q) |=> $stable(rd_data)) else $error("read data moved on store"); // R9

endmodule

// File: tb/banked_scratchpad_tb_top.sv
// Bench for banked_scratchpad. A behavioural model (integer loops and a model
// memory) predicts the service-cycle count and the read data. ready and done are
// compared on every clock of each request.
module banked_scratchpad_tb_top;
    localparam int LANES = 32;
    localparam int BANKS = 32;
    localparam int WORDS = 2048;
    localparam int DW    = 32;
    localparam int AW    = $clog2(WORDS);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_write = 1'b0;
    logic req_wide = 1'b0;
    logic [LANES-1:0]         req_mask = '0;
    logic [LANES-1:0][AW-1:0] req_addr = '0;
    logic [LANES-1:0][DW-1:0] req_wdata = '0;
    logic ready;
    logic done;
    logic [LANES-1:0][DW-1:0] rd_data;

    int checks = 0;
    int failures = 0;
    logic [DW-1:0] model_mem [WORDS];

    always #5 clk = ~clk;

    banked_scratchpad #(.LANES(LANES), .BANKS(BANKS), .WORDS(WORDS), .DW(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_wide(req_wide), .req_mask(req_mask), .req_addr(req_addr),
        .req_wdata(req_wdata), .ready(ready), .done(done), .rd_data(rd_data)
    );

    task automatic check(input string tag, input logic ok, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Model: number of service cycles = max distinct bank words per bank.
    function automatic int model_cycles();
        int cnt [BANKS];
        int worst = 1;
        for (int b = 0; b < BANKS; b++) cnt[b] = 0;
        for (int i = 0; i < LANES; i++) begin
            if (req_mask[i]) begin
                int ki = req_wide ? int'(req_addr[i]) / 2 : int'(req_addr[i]);
                bit first = 1'b1;
                for (int j = 0; j < i; j++) begin
                    int kj = req_wide ? int'(req_addr[j]) / 2 : int'(req_addr[j]);
                    if (req_mask[j] && kj == ki) first = 1'b0;
                end
                if (first) cnt[ki % BANKS]++;
            end
        end
        for (int b = 0; b < BANKS; b++) if (cnt[b] > worst) worst = cnt[b];
        return worst;
    endfunction

    // Issue the request now on the pins, check ready/done each clock and the data.
    // With spoof set, a store to address 5 is presented throughout the replay.
    task automatic run_req(input string tag, input bit spoof);
        int s_exp = model_cycles();
        logic [LANES-1:0][DW-1:0] exp_rd = '0;
        bit was_write = req_write;
        int bad_lane = -1;
        for (int i = 0; i < LANES; i++) begin
            if (req_mask[i] && !req_write) exp_rd[i] = model_mem[req_addr[i]];
        end
        if (req_write) begin
            for (int i = 0; i < LANES; i++)
                if (req_mask[i]) model_mem[req_addr[i]] = req_wdata[i];
        end
        req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        if (spoof) begin
            req_write = 1'b1;
            req_mask  = '1;
            for (int i = 0; i < LANES; i++) begin
                req_addr[i]  = AW'(5);
                req_wdata[i] = 32'hBAD0_0000 + DW'(i);
            end
        end else begin
            req_valid = 1'b0;
        end
        check(tag, ready == 1'b0 && done == 1'b0, "ready low after accept", ready, 0);
        for (int k = 1; k <= s_exp; k++) begin
            @(posedge clk);
            @(negedge clk);
            check(tag, done == (k == s_exp), "done timing", done, (k == s_exp));
            check("R10", ready == (k == s_exp), "ready timing", ready, (k == s_exp));
        end
        req_valid = 1'b0;
        for (int i = 0; i < LANES; i++) begin
            if (rd_data[i] !== exp_rd[i] && bad_lane < 0) bad_lane = i;
        end
        check(was_write ? "R9" : tag, bad_lane < 0, "rd_data lane",
              bad_lane < 0 ? 0 : rd_data[bad_lane], bad_lane < 0 ? 0 : exp_rd[bad_lane]);
        @(posedge clk);
        @(negedge clk);
        check("R10", done == 1'b0 && ready == 1'b1, "done one cycle", done, 0);
    endtask

    task automatic set_req(input bit wr, input bit wide, input logic [LANES-1:0] m);
        req_write = wr;
        req_wide  = wide;
        req_mask  = m;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        check("R1", ready == 1'b1 && done == 1'b0, "reset ready/done", {ready, done}, 2);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", ready == 1'b1 && done == 1'b0, "after reset", {ready, done}, 2);

        // R2: fill all storage with stride-1 narrow stores, one cycle each.
        for (int blk = 0; blk < WORDS / LANES; blk++) begin
            set_req(1'b1, 1'b0, '1);
            for (int i = 0; i < LANES; i++) begin
                req_addr[i]  = AW'(blk * LANES + i);
                req_wdata[i] = 32'h5000_0000 + DW'((blk * LANES + i) * 3);
            end
            run_req("R2", 1'b0);
        end
        // R2: stride-1 narrow load.
        set_req(1'b0, 1'b0, '1);
        for (int i = 0; i < LANES; i++) req_addr[i] = AW'(64 + i);
        run_req("R2", 1'b0);
        // R6: stride 2 narrow -> 2 cycles; wide -> 1 cycle (R5).
        for (int i = 0; i < LANES; i++) req_addr[i] = AW'(2 * i);
        run_req("R6", 1'b0);
        req_wide = 1'b1;
        run_req("R5", 1'b0);
        // R7: stride 3 narrow -> 1 cycle.
        req_wide = 1'b0;
        for (int i = 0; i < LANES; i++) req_addr[i] = AW'(3 * i + 7);
        run_req("R7", 1'b0);
        // R4: all lanes one address.
        for (int i = 0; i < LANES; i++) req_addr[i] = AW'(300);
        run_req("R4", 1'b0);
        // R4: two broadcast groups in banks 12 and 20 -> 1 cycle.
        for (int i = 0; i < LANES; i++) req_addr[i] = AW'(i < 16 ? 12 : 52);
        run_req("R4", 1'b0);
        // R3: two broadcast groups in the same bank 12 -> 2 cycles.
        for (int i = 0; i < LANES; i++) req_addr[i] = AW'(i < 16 ? 12 : 44);
        run_req("R3", 1'b0);
        // R3: every lane in bank 0, distinct words -> 32 cycles.
        for (int i = 0; i < LANES; i++) req_addr[i] = AW'(32 * i);
        run_req("R3", 1'b0);
        // R3: scattered addresses mixing broadcasts and conflicts.
        for (int i = 0; i < LANES; i++) req_addr[i] = AW'((i * i * 7 + 3) % 256);
        run_req("R3", 1'b0);
        // R5: wide mode, pairs in a line, 16 lines all in bank 0 -> 16 cycles.
        req_wide = 1'b1;
        for (int i = 0; i < LANES; i++) req_addr[i] = AW'((i / 2) * 64 + (i % 2));
        run_req("R5", 1'b0);
        // R9: partial-mask load, inactive lanes read 0.
        set_req(1'b0, 1'b0, 32'hA5A5_0F0F);
        for (int i = 0; i < LANES; i++) req_addr[i] = AW'(500 + 5 * i);
        run_req("R9", 1'b0);
        // R8: all lanes store to one address, highest lane wins; read back.
        set_req(1'b1, 1'b0, '1);
        for (int i = 0; i < LANES; i++) begin
            req_addr[i]  = AW'(100);
            req_wdata[i] = 32'hC0DE_0000 + DW'(i);
        end
        run_req("R8", 1'b0);
        set_req(1'b1, 1'b0, (32'h1 << 3) | (32'h1 << 7) | (32'h1 << 20));
        for (int i = 0; i < LANES; i++) begin
            req_addr[i]  = AW'(i == 31 ? 100 : (i == 3 || i == 7 || i == 20) ? 101 : 900 + i);
            req_wdata[i] = 32'h7700_0000 + DW'(i);
        end
        run_req("R8", 1'b0);
        set_req(1'b0, 1'b0, '1);
        for (int i = 0; i < LANES; i++) req_addr[i] = AW'(i % 2 == 0 ? 100 : 101);
        run_req("R8", 1'b0);
        // R11: empty-mask store changes nothing; read back the same words.
        set_req(1'b1, 1'b0, '0);
        for (int i = 0; i < LANES; i++) begin
            req_addr[i]  = AW'(700 + i);
            req_wdata[i] = 32'hDEAD_0000;
        end
        run_req("R11", 1'b0);
        set_req(1'b0, 1'b0, '1);
        run_req("R11", 1'b0);
        // R10: a store presented while busy must be ignored; read address 5.
        set_req(1'b1, 1'b0, '1);
        for (int i = 0; i < LANES; i++) begin
            req_addr[i]  = AW'(1000 + (i % 2) * 32 + (i / 2) * 0);
            req_wdata[i] = 32'h1234_0000 + DW'(i);
        end
        run_req("R10", 1'b1);
        set_req(1'b0, 1'b0, '1);
        for (int i = 0; i < LANES; i++) req_addr[i] = AW'(5);
        run_req("R10", 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule